// File: doc/BRIEF.md
# Autonegotiation Speed Downshift Controller

This block sits beside an Ethernet autonegotiation engine and decides which speed abilities that engine advertises. After reset it advertises every speed the configuration enables, gigabit included. It counts negotiation attempts that fail. Once a programmed number of failures is reached, it removes the highest speed still offered and asks the engine to restart negotiation. The fallback goes from 1000 to 100 to 10 Mb/s. After the 10 Mb/s level fails as well, every enabled speed is offered again and the walk starts over from the top.

A single enable turns the whole feature on or off. A second bit decides whether the 10 Mb/s-only step is allowed. When it is not, a failed 100 Mb/s level wraps straight back to full advertisement. A link-up pulse clears the failure count and holds the current level. A software restart input, or the asynchronous reset, brings back full advertisement. The negotiation protocol, the physical layer and the register file are outside this block.

Top module: `spd_downshift_ctrl`

## Requirements
- R1: While in reset and after it, adv_mask_o equals cfg_ability_i, restart_an_o is 0 and downshifted_o is 0. Mask bit 2 is 1000 Mb/s, bit 1 is 100 Mb/s and bit 0 is 10 Mb/s.
- R2: fail_limit_i code 0, 1, 2 or 3 selects 1, 2, 3 or 4 failed attempts per level. The level changes on the clock edge that samples the failure which reaches the limit.
- R3: At the full level, reaching the limit sets adv_mask_o to cfg_ability_i & 3'b011.
- R4: At the no-gigabit level with allow_10_i high, reaching the limit sets adv_mask_o to cfg_ability_i & 3'b001.
- R5: At the 10 Mb/s-only level, reaching the limit restores adv_mask_o to cfg_ability_i.
- R6: At the no-gigabit level with allow_10_i low, reaching the limit restores adv_mask_o to cfg_ability_i. The 10-only level is never entered.
- R7: With en_i low, the level returns to full one cycle later, and attempt_fail_i pulses are ignored.
- R8: A link_up_i pulse clears the failure count and leaves the advertisement unchanged.
- R9: restart_an_o is a one-cycle pulse that rises one cycle after adv_mask_o changes level.
- R10: downshifted_o is high exactly when adv_mask_o leaves out a speed that cfg_ability_i enables.
- R11: A sw_restart_i pulse returns the controller to the full level and clears the failure count on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Downshift feature enable |
| allow_10_i | input | 1 | Permit the 10 Mb/s-only level |
| cfg_ability_i | input | 3 | Enabled speeds {1000,100,10} |
| fail_limit_i | input | 2 | Failures per level, minus one |
| link_up_i | input | 1 | Link established pulse |
| attempt_fail_i | input | 1 | Negotiation attempt failed pulse |
| sw_restart_i | input | 1 | Software restart pulse |
| adv_mask_o | output | 3 | Advertised speed abilities |
| restart_an_o | output | 1 | Restart negotiation pulse |
| downshifted_o | output | 1 | Advertisement reduced from configuration |

## Verification
Assertions check several properties on every cycle. The restart pulse lasts one cycle and follows a level change. A disabled feature or a software restart brings the level back to full. A link-up holds the level and clears the count. The 10-only level is never reached while it is disallowed, and the downshifted flag always matches the mask. Only the bench scenarios can show that the failure count matches the programmed limit at each code, that the ladder wraps correctly with and without the 10 Mb/s step, and that masks come out right for sparse ability configurations.

// File: rtl/spd_ds_pkg.sv
package spd_ds_pkg;
  localparam int NUM_SPD = 3;
  localparam int LIM_W   = 2;

  typedef enum logic [1:0] {
    LV_FULL   = 2'd0,
    LV_NO1G   = 2'd1,
    LV_ONLY10 = 2'd2
  } lvl_e;
endpackage

// File: rtl/spd_fail_counter.sv
module spd_fail_counter
  import spd_ds_pkg::*;
#(
  parameter int LW = LIM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clear_i,
  input  logic          link_up_i,
  input  logic          fail_i,
  input  logic [LW-1:0] limit_i,
  output logic          step_o
);
  logic [LW-1:0] cnt_q;
  logic          hold_clr;

  assign hold_clr = clear_i | ~en_i | link_up_i;
  assign step_o   = ~hold_clr & fail_i & (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (hold_clr || step_o) cnt_q <= '0;
    else if (fail_i)             cnt_q <= cnt_q + 1'b1;
  end

  // R8 / R11: count cleared after link-up or restart
  a_r8_link_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_up_i || clear_i) |=> (cnt_q == '0));
  a_r7_no_step_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !step_o);
endmodule

// File: rtl/spd_level_fsm.sv
module spd_level_fsm
  import spd_ds_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic allow_10_i,
  input  logic clear_i,
  input  logic step_i,
  output lvl_e level_o,
  output logic restart_o
);
  lvl_e level_q, level_d, prev_q;
  logic restart_q;

  always_comb begin
    level_d = level_q;
    if (clear_i || !en_i) level_d = LV_FULL;
    else if (step_i) begin
      unique case (level_q)
        LV_FULL:   level_d = LV_NO1G;
        LV_NO1G:   level_d = allow_10_i ? LV_ONLY10 : LV_FULL;
        default:   level_d = LV_FULL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q   <= LV_FULL;
      prev_q    <= LV_FULL;
      restart_q <= 1'b0;
    end else begin
      level_q   <= level_d;
      prev_q    <= level_q;
      restart_q <= (level_q != prev_q);
    end
  end

  assign level_o   = level_q;
  assign restart_o = restart_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |=> !restart_q);
  a_r9_follows_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |=> restart_q);
  a_r7_disabled_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || clear_i) |=> (level_q == LV_FULL));
  a_r8_level_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && !step_i) |=> (level_q == $past(level_q)));
  a_r6_no_10_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == LV_NO1G && !allow_10_i) |=> (level_q != LV_ONLY10));
endmodule

// File: rtl/spd_adv_mask.sv
module spd_adv_mask
  import spd_ds_pkg::*;
#(
  parameter int NS = NUM_SPD
) (
  input  lvl_e          level_i,
  input  logic [NS-1:0] cfg_i,
  output logic [NS-1:0] mask_o
);
  // each level drops one more speed from the top
  for (genvar i = 0; i < NS; i++) begin : g_bit
    assign mask_o[i] = cfg_i[i] & (int'(level_i) <= (NS - 1 - i));
  end
endmodule

// File: rtl/spd_downshift_ctrl.sv
module spd_downshift_ctrl
  import spd_ds_pkg::*;
#(
  parameter int NS = NUM_SPD,
  parameter int LW = LIM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          allow_10_i,
  input  logic [NS-1:0] cfg_ability_i,
  input  logic [LW-1:0] fail_limit_i,
  input  logic          link_up_i,
  input  logic          attempt_fail_i,
  input  logic          sw_restart_i,
  output logic [NS-1:0] adv_mask_o,
  output logic          restart_an_o,
  output logic          downshifted_o
);
  logic step;
  lvl_e level;

  spd_fail_counter #(.LW(LW)) u_cnt (
    .clk_i, .rst_ni, .en_i,
    .clear_i  (sw_restart_i),
    .link_up_i,
    .fail_i   (attempt_fail_i),
    .limit_i  (fail_limit_i),
    .step_o   (step)
  );

  spd_level_fsm u_fsm (
    .clk_i, .rst_ni, .en_i, .allow_10_i,
    .clear_i   (sw_restart_i),
    .step_i    (step),
    .level_o   (level),
    .restart_o (restart_an_o)
  );

  spd_adv_mask #(.NS(NS)) u_mask (
    .level_i (level),
    .cfg_i   (cfg_ability_i),
    .mask_o  (adv_mask_o)
  );

  assign downshifted_o = |(cfg_ability_i & ~adv_mask_o);

  a_r10_flag_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    downshifted_o == (adv_mask_o != cfg_ability_i));
  a_r1_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_mask_o & ~cfg_ability_i) == '0);
endmodule

// File: tb/sim_spd_downshift_ctrl.sv
module sim_spd_downshift_ctrl;
  logic       clk_i = 0, rst_ni = 0, en_i = 1, allow_10_i = 1;
  logic [2:0] cfg_ability_i = 3'b111;
  logic [1:0] fail_limit_i = 0;
  logic       link_up_i = 0, attempt_fail_i = 0, sw_restart_i = 0;
  logic [2:0] adv_mask_o;
  logic       restart_an_o, downshifted_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  spd_downshift_ctrl u0 (.*);

  // {cfg[2:0], allow10, limit[1:0], nfails[3:0], exp_mask[2:0]}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {3'b111, 1'b1, 2'd0, 4'd1, 3'b011},  // R3
    {3'b111, 1'b1, 2'd0, 4'd2, 3'b001},  // R4
    {3'b111, 1'b1, 2'd0, 4'd3, 3'b111},  // R5
    {3'b111, 1'b1, 2'd1, 4'd3, 3'b011},  // R2
    {3'b111, 1'b1, 2'd3, 4'd3, 3'b111},  // R2
    {3'b111, 1'b1, 2'd3, 4'd8, 3'b001},  // R2
    {3'b111, 1'b0, 2'd0, 4'd2, 3'b111},  // R6
    {3'b111, 1'b0, 2'd2, 4'd9, 3'b011},  // R6
    {3'b110, 1'b1, 2'd1, 4'd4, 3'b000},  // R4
    {3'b011, 1'b1, 2'd0, 4'd1, 3'b011}   // R10
  };

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic fail_pulse();
    @(negedge clk_i) attempt_fail_i = 1;
    @(negedge clk_i) attempt_fail_i = 0;
  endtask

  task automatic link_pulse();
    @(negedge clk_i) link_up_i = 1;
    @(negedge clk_i) link_up_i = 0;
  endtask

  task automatic sw_pulse();
    @(negedge clk_i) sw_restart_i = 1;
    @(negedge clk_i) sw_restart_i = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 mask in reset", {1'b0, adv_mask_o}, 4'h7);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 mask", {1'b0, adv_mask_o}, 4'h7);
    chk("R1 restart", {3'b0, restart_an_o}, 0);
    chk("R1 flag", {3'b0, downshifted_o}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      e = VEC[v];
      cfg_ability_i = e[12:10];
      allow_10_i    = e[9];
      fail_limit_i  = e[8:7];
      sw_pulse();
      for (int k = 0; k < int'(e[6:3]); k++) fail_pulse();
      @(negedge clk_i);
      chk($sformatf("R2 vec%0d mask", v), {1'b0, adv_mask_o}, {1'b0, e[2:0]});
      chk($sformatf("R10 vec%0d flag", v), {3'b0, downshifted_o},
          {3'b0, e[2:0] != e[12:10]});
    end

    // R9 restart timing
    cfg_ability_i = 3'b111; allow_10_i = 1; fail_limit_i = 0;
    sw_pulse();
    repeat (3) @(negedge clk_i);
    @(negedge clk_i) attempt_fail_i = 1;
    @(negedge clk_i) attempt_fail_i = 0;
    chk("R9 mask changed", {1'b0, adv_mask_o}, 4'h3);
    chk("R9 no pulse yet", {3'b0, restart_an_o}, 0);
    @(negedge clk_i);
    chk("R9 pulse", {3'b0, restart_an_o}, 1);
    @(negedge clk_i);
    chk("R9 pulse ends", {3'b0, restart_an_o}, 0);

    // R8 link-up clears count, holds level
    fail_limit_i = 1;
    sw_pulse();
    fail_pulse();
    link_pulse();
    fail_pulse();
    @(negedge clk_i);
    chk("R8 count cleared", {1'b0, adv_mask_o}, 4'h7);
    fail_pulse();
    @(negedge clk_i);
    chk("R8 step after two", {1'b0, adv_mask_o}, 4'h3);
    link_pulse();
    repeat (3) @(negedge clk_i);
    chk("R8 level held", {1'b0, adv_mask_o}, 4'h3);

    // R7 disable restores full and ignores fails
    fail_limit_i = 0;
    @(negedge clk_i) en_i = 0;
    @(negedge clk_i);
    chk("R7 full when off", {1'b0, adv_mask_o}, 4'h7);
    for (int k = 0; k < 4; k++) fail_pulse();
    @(negedge clk_i);
    chk("R7 fails ignored", {1'b0, adv_mask_o}, 4'h7);
    en_i = 1;

    // R11 software restart clears level and count
    fail_limit_i = 0;
    fail_pulse(); fail_pulse();
    @(negedge clk_i);
    chk("R11 at 10 level", {1'b0, adv_mask_o}, 4'h1);
    fail_limit_i = 1;
    sw_pulse();
    chk("R11 full", {1'b0, adv_mask_o}, 4'h7);
    fail_pulse();
    sw_pulse();
    fail_pulse();
    @(negedge clk_i);
    chk("R11 count cleared", {1'b0, adv_mask_o}, 4'h7);

    // R1 asynchronous reset mid-run
    fail_limit_i = 0;
    fail_pulse();
    #2 rst_ni = 0;
    #1;
    chk("R1 async reset mask", {1'b0, adv_mask_o}, 4'h7);
    chk("R1 async reset flag", {3'b0, downshifted_o}, 0);
    @(negedge clk_i) rst_ni = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule